// File: doc/BRIEF.md
# PRBS Bit-Error Checker

This block sits behind a serial receiver that is being stress tested with a pseudo-random binary sequence. It takes one received bit per valid strobe and rebuilds the expected sequence locally from the same shift-register polynomial the transmitter uses. While it is locked it compares every received bit with the predicted bit and counts both the bits checked and the bits in error. The bit-error ratio is the quotient of the two counts; software works it out from them.

The checker synchronises itself without help from the transmitter. In the acquire state it loads its reference register directly from the incoming bits. It then predicts each following bit from its own register, so that a received error does not corrupt later predictions. It declares lock after a run of matching bits and falls back to acquire when errors cluster. Once a programmed number of errors has been seen, a done flag rises and both counters freeze, so a long test ends with a statistically useful error sample. A clear input restarts the measurement and keeps the lock.

Top module: `prbs_err_checker`

## Requirements
- R1: `mode_sel` selects the sequence order k and the second feedback tap: 0 selects (7,6), 1 selects (9,5), 2 selects (15,14), 3 selects (23,18) and 4 selects (31,28). The values 5 to 7 act as 0. The predicted bit is stage k XOR the second tap stage, inverted when `pol_xnor` is 1. This bit enters stage 1, so the sequence repeats every 2^k-1 bits.
- R2: In the acquire state, each of the first k valid bits is shifted straight into the reference register. These bits are not compared and not counted. Comparison starts with the next valid bit, and the same applies after every drop back to acquire.
- R3: A seed whose k stages are all zero (XOR polarity) or all one (XNOR polarity) is rejected and seeding starts over, so a constant stream of that value never locks.
- R4: After seeding, `locked` rises on the clock edge that samples the 64th consecutive matching valid bit, and not before. The bits before lock are not counted.
- R5: Valid bits are grouped into windows of 64 that begin when comparison starts. If the 8th error within one window is seen, `locked` falls and the block returns to acquire. The bit that carries that 8th error is not counted.
- R6: While locked, each valid bit adds one to `bit_count`, and each bit that differs from the prediction also adds one to `err_count`. The prediction advances from the reference register, not from the received bit. Cycles with `in_valid` low and bits seen while unlocked change nothing.
- R7: Both counters are CNT_W bits wide and stop at 2^CNT_W-1 instead of wrapping.
- R8: When `err_count` reaches the target, `done` rises on the same edge. The target is `err_target`, or 100 when `err_target` is 0. While `done` is high, neither counter changes.
- R9: A cycle with `cnt_clr` high zeroes both counters and `done` on the next edge, and leaves `locked` unchanged.
- R10: After reset, `locked` and `done` are 0, both counters are 0 and the block is in acquire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received bit is valid this cycle |
| in_bit | input | 1 | Received serial bit |
| mode_sel | input | 3 | Sequence order select |
| pol_xnor | input | 1 | 1 selects inverted (XNOR) feedback |
| err_target | input | CNT_W | Error count that ends the test; 0 means 100 |
| cnt_clr | input | 1 | Zero the counters and done |
| locked | output | 1 | Reference is in step with the stream |
| err_count | output | CNT_W | Saturating error count |
| bit_count | output | CNT_W | Saturating count of checked bits |
| done | output | 1 | Error target reached |

## Verification
A clean stream in every order and both polarities, observed one bit before and at the lock point, shows that the taps, the seeding length and the run threshold are right. Errors injected singly and well apart show that the counters advance and that the prediction survives a bad bit. A burst of eight errors at a window start shows the drop and the uncounted eighth bit. Separately, a stream of another order and a constant all-zero or all-one stream must never lock, which exposes wrong taps and a missing forbidden-seed check. Clearing, a small target, the default target and a long run with a narrow counter cover the clear, freeze and saturation behaviour.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int PRBS_REF_W = 31;

    typedef enum logic [1:0] {
        ST_ACQ,
        ST_CHK,
        ST_LOCK
    } sync_st_e;

    // order k of the selected sequence (also the long tap)
    function automatic logic [4:0] prbs_order(input logic [2:0] sel);
        case (sel)
            3'd1:    return 5'd9;
            3'd2:    return 5'd15;
            3'd3:    return 5'd23;
            3'd4:    return 5'd31;
            default: return 5'd7;
        endcase
    endfunction

    // second feedback tap of the selected sequence
    function automatic logic [4:0] prbs_tap(input logic [2:0] sel);
        case (sel)
            3'd1:    return 5'd5;
            3'd2:    return 5'd14;
            3'd3:    return 5'd18;
            3'd4:    return 5'd28;
            default: return 5'd6;
        endcase
    endfunction

endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
    import prbs_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel_i,
    input  logic       pol_i,
    input  logic       valid_i,
    input  logic       rx_i,
    input  logic       acq_i,
    output logic       exp_o,
    output logic       seed_ok_o
);
    localparam int W = PRBS_REF_W;

    typedef struct packed {
        logic [W-1:0] sreg;
        logic [4:0]   fill;
    } ref_t;

    ref_t cur_q, nxt_d;

    logic [4:0]   ord;
    logic [4:0]   tap;
    logic         fb;
    logic [W:0]   mask_wide;
    logic [W-1:0] mask;
    logic         bad_seed;

    always_comb begin
        ord       = prbs_order(mode_sel_i);
        tap       = prbs_tap(mode_sel_i);
        fb        = cur_q.sreg[ord - 5'd1] ^ cur_q.sreg[tap - 5'd1] ^ pol_i;
        exp_o     = fb;
        mask_wide = ((W+1)'(1) << ord) - (W+1)'(1);
        mask      = mask_wide[W-1:0];

        nxt_d     = cur_q;
        seed_ok_o = 1'b0;
        if (!acq_i) begin
            nxt_d.fill = '0;
        end
        if (valid_i) begin
            if (acq_i) begin
                nxt_d.sreg = {cur_q.sreg[W-2:0], rx_i};
            end else begin
                nxt_d.sreg = {cur_q.sreg[W-2:0], fb};
            end
        end
        bad_seed = pol_i ? ((nxt_d.sreg & mask) == mask)
                         : ((nxt_d.sreg & mask) == '0);
        if (valid_i && acq_i) begin
            if (cur_q.fill == ord - 5'd1) begin
                nxt_d.fill = '0;
                seed_ok_o  = !bad_seed;
            end else begin
                nxt_d.fill = cur_q.fill + 5'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R2: without a valid bit the reference register holds
    assert_ref_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(cur_q.sreg));

endmodule

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
    import prbs_chk_pkg::*;
#(
    parameter int LOCK_RUN = 64,
    parameter int WIN_LEN  = 64,
    parameter int ERR_LIM  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic rx_i,
    input  logic exp_i,
    input  logic seed_ok_i,
    output logic acq_o,
    output logic locked_o,
    output logic cnt_en_o,
    output logic miss_o
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int ERR_W = $clog2(ERR_LIM + 1);

    typedef struct packed {
        sync_st_e         st;
        logic [RUN_W-1:0] run;
        logic [WIN_W-1:0] win;
        logic [ERR_W-1:0] werr;
    } sync_t;

    sync_t cur_q, nxt_d;
    logic  drop;
    logic  [ERR_W:0] werr_next;

    always_comb begin
        nxt_d     = cur_q;
        drop      = 1'b0;
        miss_o    = valid_i && (rx_i ^ exp_i);
        werr_next = {1'b0, cur_q.werr} + (ERR_W+1)'(miss_o);
        case (cur_q.st)
            ST_ACQ: begin
                if (seed_ok_i) begin
                    nxt_d.st   = ST_CHK;
                    nxt_d.run  = '0;
                    nxt_d.win  = '0;
                    nxt_d.werr = '0;
                end
            end
            default: begin
                if (valid_i) begin
                    if (werr_next >= (ERR_W+1)'(ERR_LIM)) begin
                        drop     = 1'b1;
                        nxt_d.st = ST_ACQ;
                    end else begin
                        if (cur_q.win == WIN_W'(WIN_LEN - 1)) begin
                            nxt_d.win  = '0;
                            nxt_d.werr = '0;
                        end else begin
                            nxt_d.win  = cur_q.win + WIN_W'(1);
                            nxt_d.werr = werr_next[ERR_W-1:0];
                        end
                        if (cur_q.st == ST_CHK) begin
                            if (miss_o) begin
                                nxt_d.run = '0;
                            end else if (cur_q.run == RUN_W'(LOCK_RUN - 1)) begin
                                nxt_d.st = ST_LOCK;
                            end else begin
                                nxt_d.run = cur_q.run + RUN_W'(1);
                            end
                        end
                    end
                end
            end
        endcase
        acq_o    = (cur_q.st == ST_ACQ);
        locked_o = (cur_q.st == ST_LOCK);
        cnt_en_o = valid_i && locked_o && !drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_ACQ, run: '0, win: '0, werr: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R4: lock is only gained on a matching valid bit
    assert_lock_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(valid_i) && !$past(miss_o));

    // R5: lock is only lost on an errored valid bit
    assert_lock_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> $past(valid_i) && $past(miss_o));

endmodule

// File: rtl/prbs_err_counters.sv
module prbs_err_counters #(
    parameter int CNT_W      = 48,
    parameter int DEF_TARGET = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cnt_en_i,
    input  logic             miss_i,
    input  logic             locked_i,
    input  logic [CNT_W-1:0] target_i,
    output logic [CNT_W-1:0] bits_o,
    output logic [CNT_W-1:0] errs_o,
    output logic             done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] bits;
        logic [CNT_W-1:0] errs;
        logic             done;
    } cnt_t;

    cnt_t cur_q, nxt_d;
    logic [CNT_W-1:0] tgt;

    always_comb begin
        tgt   = (target_i == '0) ? CNT_W'(DEF_TARGET) : target_i;
        nxt_d = cur_q;
        if (clr_i) begin
            nxt_d = '0;
        end else if (cnt_en_i && !cur_q.done) begin
            if (cur_q.bits != '1) begin
                nxt_d.bits = cur_q.bits + CNT_W'(1);
            end
            if (miss_i && cur_q.errs != '1) begin
                nxt_d.errs = cur_q.errs + CNT_W'(1);
            end
            nxt_d.done = (nxt_d.errs >= tgt);
        end
        bits_o = cur_q.bits;
        errs_o = cur_q.errs;
        done_o = cur_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R7: counters never move backward except on clear
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cur_q.bits >= $past(cur_q.bits)) && (cur_q.errs >= $past(cur_q.errs)));

    // R6: nothing is counted while unlocked
    assert_unlocked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_i && !clr_i) |=> $stable(cur_q.bits) && $stable(cur_q.errs));

    // R8: counters freeze once the target is reached
    assert_done_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.done && !clr_i) |=> $stable(cur_q.bits) && $stable(cur_q.errs) && cur_q.done);

    // R9: clear empties the measurement
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cur_q.bits == '0) && (cur_q.errs == '0) && !cur_q.done);

    // R9: clear without a bit keeps the lock
    assert_clear_keeps_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && locked_i && !cnt_en_i && !miss_i) |=> locked_i);

endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker #(
    parameter int CNT_W      = 48,
    parameter int DEF_TARGET = 100,
    parameter int LOCK_RUN   = 64,
    parameter int WIN_LEN    = 64,
    parameter int ERR_LIM    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic [2:0]       mode_sel,
    input  logic             pol_xnor,
    input  logic [CNT_W-1:0] err_target,
    input  logic             cnt_clr,
    output logic             locked,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] bit_count,
    output logic             done
);
    logic exp_bit;
    logic seed_ok;
    logic acq;
    logic cnt_en;
    logic miss;

    prbs_ref_gen u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel_i (mode_sel),
        .pol_i      (pol_xnor),
        .valid_i    (in_valid),
        .rx_i       (in_bit),
        .acq_i      (acq),
        .exp_o      (exp_bit),
        .seed_ok_o  (seed_ok)
    );

    prbs_lock_fsm #(
        .LOCK_RUN (LOCK_RUN),
        .WIN_LEN  (WIN_LEN),
        .ERR_LIM  (ERR_LIM)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (in_valid),
        .rx_i      (in_bit),
        .exp_i     (exp_bit),
        .seed_ok_i (seed_ok),
        .acq_o     (acq),
        .locked_o  (locked),
        .cnt_en_o  (cnt_en),
        .miss_o    (miss)
    );

    prbs_err_counters #(
        .CNT_W      (CNT_W),
        .DEF_TARGET (DEF_TARGET)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .cnt_en_i (cnt_en),
        .miss_i   (miss),
        .locked_i (locked),
        .target_i (err_target),
        .bits_o   (bit_count),
        .errs_o   (err_count),
        .done_o   (done)
    );

endmodule

// File: tb/sim_prbs_err_checker.sv
module sim_prbs_err_checker;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_bit = 1'b0;
    logic [2:0]    mode_sel = 3'd0;
    logic          pol_xnor = 1'b0;
    logic [CW-1:0] err_target = '0;
    logic          cnt_clr = 1'b0;
    logic          locked;
    logic [CW-1:0] err_count;
    logic [CW-1:0] bit_count;
    logic          done;

    always #2.5 clk = ~clk;

    prbs_err_checker #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .mode_sel(mode_sel), .pol_xnor(pol_xnor), .err_target(err_target),
        .cnt_clr(cnt_clr), .locked(locked), .err_count(err_count),
        .bit_count(bit_count), .done(done)
    );

    typedef struct {
        string req;
        int    lk;
        int    er;
        int    bt;
        int    dn;
    } exp_item_t;

    exp_item_t sb_q[$];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // transmitter model
    logic [30:0] tx;
    int tx_k = 7;
    int tx_t = 6;
    bit tx_pol = 1'b0;

    function automatic void tx_cfg(input int m, input bit p);
        case (m)
            1: begin tx_k = 9;  tx_t = 5;  end
            2: begin tx_k = 15; tx_t = 14; end
            3: begin tx_k = 23; tx_t = 18; end
            4: begin tx_k = 31; tx_t = 28; end
            default: begin tx_k = 7; tx_t = 6; end
        endcase
        tx_pol = p;
    endfunction

    function automatic bit tx_step();
        bit nb;
        nb = tx[tx_k-1] ^ tx[tx_t-1] ^ tx_pol;
        tx = {tx[29:0], nb};
        return nb;
    endfunction

    // driver side
    task automatic push(input string r, input int lk, input int er, input int bt, input int dn);
        exp_item_t it;
        it.req = r; it.lk = lk; it.er = er; it.bt = bt; it.dn = dn;
        sb_q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset(input int dm, input int tm, input bit p);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        mode_sel = 3'(dm);
        pol_xnor = p;
        tx_cfg(tm, p);
        tx = 31'h1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // kind: 0 sequence, 1 constant zero, 2 constant one
    task automatic send(input int n, input int every, input int kind);
        for (int i = 0; i < n; i++) begin
            bit b;
            if (kind == 1) b = 1'b0;
            else if (kind == 2) b = 1'b1;
            else b = tx_step();
            if (every != 0 && (i % every) == every - 1) b = ~b;
            @(negedge clk);
            in_valid = 1'b1;
            in_bit = b;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    // monitor side
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (int'(locked) != it.lk || int'(err_count) != it.er ||
                int'(bit_count) != it.bt || int'(done) != it.dn) begin
                failures++;
                $display("FAIL %s: got locked=%0d err=%0d bits=%0d done=%0d, expected locked=%0d err=%0d bits=%0d done=%0d",
                         it.req, locked, err_count, bit_count, done, it.lk, it.er, it.bt, it.dn);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        do_reset(0, 0, 1'b0);
        push("R10", 0, 0, 0, 0);

        // R2 R4: seeding plus one short of the lock run
        send(7 + 63, 0, 0);
        push("R4", 0, 0, 0, 0);
        send(1, 0, 0);
        push("R4", 1, 0, 0, 0);
        send(200, 0, 0);
        push("R6", 1, 0, 200, 0);
        repeat (5) @(negedge clk);
        push("R6", 1, 0, 200, 0);

        // R6: spaced errors counted, prediction not disturbed
        send(200, 20, 0);
        push("R6", 1, 10, 400, 0);

        // R9 clear keeps lock
        pulse_clear();
        push("R9", 1, 0, 0, 0);

        // R8 small target freezes counters
        err_target = CW'(5);
        send(120, 20, 0);
        push("R8", 1, 5, 100, 1);

        // R8 default target, R7 saturation
        err_target = '0;
        pulse_clear();
        push("R9", 1, 0, 0, 0);
        send(1600, 16, 0);
        push("R7", 1, 100, 1023, 1);

        // R5 burst at window start drops lock
        do_reset(0, 0, 1'b0);
        send(7 + 64, 0, 0);
        send(64, 0, 0);
        push("R5", 1, 0, 64, 0);
        send(8, 1, 0);
        push("R5", 0, 7, 71, 0);
        send(7 + 64, 0, 0);
        push("R2", 1, 7, 71, 0);

        // R1 each order and polarity
        do_reset(1, 1, 1'b0);
        send(9 + 64 + 100, 0, 0);
        push("R1", 1, 0, 100, 0);
        do_reset(2, 2, 1'b1);
        send(15 + 64 + 100, 0, 0);
        push("R1", 1, 0, 100, 0);
        do_reset(3, 3, 1'b0);
        send(23 + 64 + 100, 0, 0);
        push("R1", 1, 0, 100, 0);
        do_reset(4, 4, 1'b1);
        send(31 + 64 + 100, 0, 0);
        push("R1", 1, 0, 100, 0);
        do_reset(5, 0, 1'b1);
        send(7 + 64 + 100, 0, 0);
        push("R1", 1, 0, 100, 0);

        // R1 stream of another order never locks
        do_reset(0, 2, 1'b0);
        send(300, 0, 0);
        push("R1", 0, 0, 0, 0);

        // R3 forbidden seeds
        do_reset(0, 0, 1'b0);
        send(200, 0, 1);
        push("R3", 0, 0, 0, 0);
        do_reset(1, 1, 1'b1);
        send(200, 0, 2);
        push("R3", 0, 0, 0, 0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule